// File: doc/BRIEF.md
# Hot-Swap Fault Retry Controller

This block is the digital policy engine that sits next to a hot-swap gate driver on a 48 V input. It takes comparator flags for current limit, input undervoltage, input overvoltage, a hard short and output-bus good. It also takes a slow tick enable that paces every timer. From these it decides whether the pass switch is off, waiting for a valid input, ramping, fully on, cooling down after a fault, or locked off. Its outputs are a gate enable, a power-good, a fault pin, a cause code and a count of the automatic restarts used so far.

Faults are sorted into two kinds. A hard short locks the switch off at once. Benign events are a brownout, an overvoltage, or current limit held for too long. They turn the switch off for a minimum off-time and then allow an automatic restart. After a bounded number of such restarts the block also locks off, so a persistent fault is never hammered. The lock clears only on a host unlock pulse or when the input is removed for a long time. The restart count clears once the switch has run cleanly for a set time.

Top module: `hsw_retry_ctrl`

## Requirements
- R1: After reset, gate_en_o, pgood_o and fault_o are 0, and cause_o and retry_o are 0. The block stays off while on_req_i is 0.
- R2: A raw undervoltage or overvoltage flag counts only after it has been high for DEB_SET_TICKS consecutive ticks. It is released only after it has been low for DEB_CLR_TICKS consecutive ticks. Shorter pulses have no effect. Undervoltage is taken as present from reset.
- R3: The gate turns on only when undervoltage and overvoltage are both released. pgood_o rises only after vbus_ok_i has been high for PG_TICKS consecutive ticks while the gate is on, and pgood_o is never high while the gate is off.
- R4: While the gate is on, current limit held for FLT_TICKS consecutive ticks is a benign fault with cause 1. A shorter burst restarts the timer.
- R5: A benign fault turns the gate off and raises fault_o. It adds one to retry_o and sets the cause: 1 for the current-limit timer, 2 for undervoltage, 3 for overvoltage. When both are qualified, undervoltage takes priority over overvoltage, and overvoltage over the timer.
- R6: After a benign fault the gate stays off for at least OFF_TICKS ticks before the next automatic restart.
- R7: A benign fault that arrives when retry_o already equals MAX_RETRY locks the block off. The cause becomes 5 and retry_o stays at MAX_RETRY.
- R8: A short flag while the gate is on turns the gate off on the next clock, with or without a tick. The block locks off with cause 4 and retry_o unchanged.
- R9: While locked, the gate stays off and fault_o stays high. The lock clears on an unlock_i pulse, or when undervoltage stays qualified for REMOVE_TICKS consecutive ticks. Either exit sets cause_o and retry_o to 0 and restarts from off.
- R10: Once the block has stayed fully on for GOOD_RUN_TICKS consecutive ticks, retry_o returns to 0.
- R11: While tick_i is low, no timer or qualifier advances.
- R12: Dropping on_req_i outside the lock turns the gate and power-good off and sets cause_o to 0, without raising fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase enable, one clock wide |
| on_req_i | input | 1 | Host request to run the switch |
| ilim_i | input | 1 | Current limit engaged |
| uv_raw_i | input | 1 | Raw input undervoltage comparator |
| ov_raw_i | input | 1 | Raw input overvoltage comparator |
| short_i | input | 1 | Hard short detected |
| vbus_ok_i | input | 1 | Output bus above its good level |
| unlock_i | input | 1 | Host pulse that clears the lock |
| gate_en_o | output | 1 | Pass switch gate enable |
| pgood_o | output | 1 | Power-good |
| fault_o | output | 1 | Fault pin: high in cooldown or lock |
| cause_o | output | 3 | Last fault cause (0 none, 1 timer, 2 UV, 3 OV, 4 short, 5 retries exhausted) |
| retry_o | output | $clog2(MAX_RETRY+1) | Automatic restarts used |

## Verification
The hardest condition to reach from the ports is the lock caused by an exhausted retry budget. It needs MAX_RETRY + 1 benign faults with no gap long enough for the good-run timer to clear the count. The bench holds current limit high across every restart, so each restart faults again inside the ramp-and-on window, well before the good-run time. It then checks the restart count after each trip and the cause code after the last one. Exit from the lock by input removal is reached in the same way: a lock is first forced with a short, then undervoltage is held through qualification plus the removal window, and the exit edge is sampled on its exact cycle.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_WAIT  = 3'd1,
      ST_RAMP  = 3'd2,
      ST_ON    = 3'd3,
      ST_COOL  = 3'd4,
      ST_LATCH = 3'd5
   } hsw_state_e;

   typedef enum logic [2:0] {
      CZ_NONE    = 3'd0,
      CZ_ILIM    = 3'd1,
      CZ_UV      = 3'd2,
      CZ_OV      = 3'd3,
      CZ_SHORT   = 3'd4,
      CZ_EXHAUST = 3'd5
   } hsw_cause_e;
endpackage

// File: rtl/hsw_qual.sv
// Debounce qualifier: asymmetric set/release counts give time hysteresis.
module hsw_qual #(
   parameter int CNT_W     = 8,
   parameter int SET_TICKS = 4,
   parameter int CLR_TICKS = 8,
   parameter bit INIT      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic raw_i,
   output logic qual_o
);
   localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SET_TICKS);
   localparam logic [CNT_W-1:0] CLR_LIM = CNT_W'(CLR_TICKS);

   logic             q_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   assign lim    = q_q ? CLR_LIM : SET_LIM;
   assign qual_o = q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q   <= INIT;
         cnt_q <= '0;
      end else if (tick_i) begin
         if (raw_i != q_q) begin
            if (cnt_q + 1'b1 >= lim) begin
               q_q   <= raw_i;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
   import hsw_pkg::*;
#(
   parameter int CNT_W          = 8,
   parameter int FLT_TICKS      = 8,
   parameter int OFF_TICKS      = 10,
   parameter int PG_TICKS       = 4,
   parameter int GOOD_RUN_TICKS = 20,
   parameter int REMOVE_TICKS   = 30,
   parameter int MAX_RETRY      = 2,
   parameter int RW             = $clog2(MAX_RETRY + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          on_req_i,
   input  logic          ilim_i,
   input  logic          short_i,
   input  logic          vbus_ok_i,
   input  logic          unlock_i,
   input  logic          uv_q_i,
   input  logic          ov_q_i,
   output hsw_state_e    state_o,
   output hsw_cause_e    cause_o,
   output logic [RW-1:0] retry_o
);
   localparam logic [CNT_W-1:0] FLT_LIM  = CNT_W'(FLT_TICKS);
   localparam logic [CNT_W-1:0] OFF_LIM  = CNT_W'(OFF_TICKS);
   localparam logic [CNT_W-1:0] PG_LIM   = CNT_W'(PG_TICKS);
   localparam logic [CNT_W-1:0] GOOD_LIM = CNT_W'(GOOD_RUN_TICKS);
   localparam logic [CNT_W-1:0] RM_LIM   = CNT_W'(REMOVE_TICKS);
   localparam logic [RW-1:0]    RET_LIM  = RW'(MAX_RETRY);

   hsw_state_e       state_q;
   hsw_cause_e       cause_q;
   logic [RW-1:0]    retry_q;
   logic [CNT_W-1:0] ph_q;    // shared phase counter: pg qual / off-time / removal
   logic [CNT_W-1:0] ilim_q;  // current-limit dwell timer
   logic [CNT_W-1:0] good_q;  // clean-run timer
   logic             benign;
   hsw_cause_e       bcause;
   logic             powered;

   assign powered = (state_q == ST_RAMP) || (state_q == ST_ON);

   always_comb begin
      benign = 1'b0;
      bcause = CZ_NONE;
      if (uv_q_i) begin
         benign = 1'b1;
         bcause = CZ_UV;
      end else if (ov_q_i) begin
         benign = 1'b1;
         bcause = CZ_OV;
      end else if (ilim_i && (ilim_q + 1'b1 >= FLT_LIM)) begin
         benign = 1'b1;
         bcause = CZ_ILIM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         cause_q <= CZ_NONE;
         retry_q <= '0;
         ph_q    <= '0;
         ilim_q  <= '0;
         good_q  <= '0;
      end else if (state_q == ST_LATCH) begin
         if (unlock_i) begin
            state_q <= ST_OFF;
            cause_q <= CZ_NONE;
            retry_q <= '0;
            ph_q    <= '0;
         end else if (tick_i) begin
            if (uv_q_i) begin
               if (ph_q + 1'b1 >= RM_LIM) begin
                  state_q <= ST_OFF;
                  cause_q <= CZ_NONE;
                  retry_q <= '0;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end else begin
               ph_q <= '0;
            end
         end
      end else if (!on_req_i) begin
         state_q <= ST_OFF;
         cause_q <= CZ_NONE;
         ph_q    <= '0;
         ilim_q  <= '0;
         good_q  <= '0;
      end else if (powered && short_i) begin
         state_q <= ST_LATCH;
         cause_q <= CZ_SHORT;
         ph_q    <= '0;
         ilim_q  <= '0;
         good_q  <= '0;
      end else if (tick_i) begin
         unique case (state_q)
            ST_OFF: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (!uv_q_i && !ov_q_i) begin
                  state_q <= ST_RAMP;
                  ph_q    <= '0;
                  ilim_q  <= '0;
               end
            end
            ST_RAMP, ST_ON: begin
               if (benign) begin
                  ph_q   <= '0;
                  ilim_q <= '0;
                  good_q <= '0;
                  if (retry_q >= RET_LIM) begin
                     state_q <= ST_LATCH;
                     cause_q <= CZ_EXHAUST;
                  end else begin
                     state_q <= ST_COOL;
                     cause_q <= bcause;
                     retry_q <= retry_q + 1'b1;
                  end
               end else begin
                  ilim_q <= ilim_i ? ilim_q + 1'b1 : '0;
                  if (state_q == ST_RAMP) begin
                     if (vbus_ok_i) begin
                        if (ph_q + 1'b1 >= PG_LIM) begin
                           state_q <= ST_ON;
                           good_q  <= '0;
                        end else begin
                           ph_q <= ph_q + 1'b1;
                        end
                     end else begin
                        ph_q <= '0;
                     end
                  end else if (good_q + 1'b1 >= GOOD_LIM) begin
                     retry_q <= '0;
                  end else begin
                     good_q <= good_q + 1'b1;
                  end
               end
            end
            ST_COOL: begin
               if (ph_q + 1'b1 >= OFF_LIM) begin
                  state_q <= ST_WAIT;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: state_q <= ST_OFF;
         endcase
      end
   end

   assign state_o = state_q;
   assign cause_o = cause_q;
   assign retry_o = retry_q;
endmodule

// File: rtl/hsw_retry_ctrl.sv
module hsw_retry_ctrl
   import hsw_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int DEB_SET_TICKS  = 16,
   parameter int DEB_CLR_TICKS  = 64,
   parameter int FLT_TICKS      = 1000,
   parameter int OFF_TICKS      = 5000,
   parameter int PG_TICKS       = 50,
   parameter int GOOD_RUN_TICKS = 20000,
   parameter int REMOVE_TICKS   = 30000,
   parameter int MAX_RETRY      = 3,
   localparam int RW            = $clog2(MAX_RETRY + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          on_req_i,
   input  logic          ilim_i,
   input  logic          uv_raw_i,
   input  logic          ov_raw_i,
   input  logic          short_i,
   input  logic          vbus_ok_i,
   input  logic          unlock_i,
   output logic          gate_en_o,
   output logic          pgood_o,
   output logic          fault_o,
   output logic [2:0]    cause_o,
   output logic [RW-1:0] retry_o
);
   localparam int LIM_MAX = 2 ** CNT_W - 1;

   initial begin
      assert (MAX_RETRY >= 1) else $error("MAX_RETRY must be at least 1");
      assert (DEB_SET_TICKS >= 1 && DEB_SET_TICKS <= LIM_MAX)
         else $error("DEB_SET_TICKS out of range");
      assert (DEB_CLR_TICKS >= 1 && DEB_CLR_TICKS <= LIM_MAX)
         else $error("DEB_CLR_TICKS out of range");
      assert (FLT_TICKS >= 1 && FLT_TICKS <= LIM_MAX) else $error("FLT_TICKS out of range");
      assert (OFF_TICKS >= 1 && OFF_TICKS <= LIM_MAX) else $error("OFF_TICKS out of range");
      assert (PG_TICKS >= 1 && PG_TICKS <= LIM_MAX) else $error("PG_TICKS out of range");
      assert (GOOD_RUN_TICKS >= 1 && GOOD_RUN_TICKS <= LIM_MAX)
         else $error("GOOD_RUN_TICKS out of range");
      assert (REMOVE_TICKS >= 1 && REMOVE_TICKS <= LIM_MAX)
         else $error("REMOVE_TICKS out of range");
   end

   // index 0: undervoltage (present from reset), index 1: overvoltage
   logic [1:0] raw_vec;
   logic [1:0] qual_vec;
   assign raw_vec = {ov_raw_i, uv_raw_i};

   for (genvar g = 0; g < 2; g++) begin : g_qual
      hsw_qual #(
         .CNT_W    (CNT_W),
         .SET_TICKS(DEB_SET_TICKS),
         .CLR_TICKS(DEB_CLR_TICKS),
         .INIT     (g == 0)
      ) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .tick_i(tick_i),
         .raw_i (raw_vec[g]),
         .qual_o(qual_vec[g])
      );
   end

   hsw_state_e st;
   hsw_cause_e cz;

   hsw_fsm #(
      .CNT_W         (CNT_W),
      .FLT_TICKS     (FLT_TICKS),
      .OFF_TICKS     (OFF_TICKS),
      .PG_TICKS      (PG_TICKS),
      .GOOD_RUN_TICKS(GOOD_RUN_TICKS),
      .REMOVE_TICKS  (REMOVE_TICKS),
      .MAX_RETRY     (MAX_RETRY),
      .RW            (RW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .on_req_i (on_req_i),
      .ilim_i   (ilim_i),
      .short_i  (short_i),
      .vbus_ok_i(vbus_ok_i),
      .unlock_i (unlock_i),
      .uv_q_i   (qual_vec[0]),
      .ov_q_i   (qual_vec[1]),
      .state_o  (st),
      .cause_o  (cz),
      .retry_o  (retry_o)
   );

   assign gate_en_o = (st == ST_RAMP) || (st == ST_ON);
   assign pgood_o   = (st == ST_ON);
   assign fault_o   = (st == ST_COOL) || (st == ST_LATCH);
   assign cause_o   = cz;
endmodule

// File: rtl/hsw_retry_ctrl_chk.sv
module hsw_retry_ctrl_chk #(
   parameter int CNT_W     = 16,
   parameter int OFF_TICKS = 5000,
   parameter int MAX_RETRY = 3,
   parameter int RW        = $clog2(MAX_RETRY + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_i,
   input logic          on_req_i,
   input logic          short_i,
   input logic          vbus_ok_i,
   input logic          unlock_i,
   input logic          gate_en_o,
   input logic          pgood_o,
   input logic          fault_o,
   input logic [2:0]    cause_o,
   input logic [RW-1:0] retry_o
);
   localparam logic [CNT_W:0] OFF_LIM = (CNT_W + 1)'(OFF_TICKS);

   // ticks spent with the fault pin high since the gate was last on
   logic [CNT_W:0] off_ticks;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         off_ticks <= '0;
      else if (gate_en_o)                                 off_ticks <= '0;
      else if (fault_o && tick_i && off_ticks < OFF_LIM)  off_ticks <= off_ticks + 1'b1;
   end

   a_r3_pg_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_o |-> gate_en_o);

   a_r3_pg_after_vbus: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood_o) |-> $past(vbus_ok_i));

   a_r5_fault_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !gate_en_o);

   a_r5_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_o != $past(retry_o)) |-> (retry_o == $past(retry_o) + 1'b1 || retry_o == '0));

   a_r6_min_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_en_o) && cause_o inside {3'd1, 3'd2, 3'd3}) |-> (off_ticks >= OFF_LIM));

   a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o <= RW'(MAX_RETRY));

   a_r8_short_trips: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en_o && short_i && on_req_i) |=> (!gate_en_o && cause_o == 3'd4));

   a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_o == 3'd4 || cause_o == 3'd5) && !unlock_i) |=> !gate_en_o);
endmodule

bind hsw_retry_ctrl hsw_retry_ctrl_chk #(
   .CNT_W    (CNT_W),
   .OFF_TICKS(OFF_TICKS),
   .MAX_RETRY(MAX_RETRY),
   .RW       (RW)
) u_chk (.*);

// File: tb/tb_hsw_retry_ctrl.sv
module tb_hsw_retry_ctrl;
   localparam int CNT_W = 8;
   localparam int DSET  = 3;
   localparam int DCLR  = 5;
   localparam int FLT   = 8;
   localparam int OFFT  = 10;
   localparam int PGT   = 4;
   localparam int GOOD  = 20;
   localparam int RMV   = 30;
   localparam int MAXR  = 2;
   localparam int RW    = $clog2(MAXR + 1);

   logic clk = 1'b0;
   logic rst_n, tick_i, on_req_i, ilim_i, uv_raw_i, ov_raw_i, short_i, vbus_ok_i, unlock_i;
   logic gate_en_o, pgood_o, fault_o;
   logic [2:0] cause_o;
   logic [RW-1:0] retry_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   hsw_retry_ctrl #(
      .CNT_W(CNT_W), .DEB_SET_TICKS(DSET), .DEB_CLR_TICKS(DCLR), .FLT_TICKS(FLT),
      .OFF_TICKS(OFFT), .PG_TICKS(PGT), .GOOD_RUN_TICKS(GOOD), .REMOVE_TICKS(RMV),
      .MAX_RETRY(MAXR)
   ) dut (.*);

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick_i = 1'b1; on_req_i = 1'b0; ilim_i = 1'b0; uv_raw_i = 1'b1;
      ov_raw_i = 1'b0; short_i = 1'b0; vbus_ok_i = 1'b0; unlock_i = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   task automatic wait_gate(input logic v);
      for (int i = 0; i < 80; i++) begin
         if (gate_en_o == v) break;
         cyc(1);
      end
   endtask

   task automatic wait_pg();
      for (int i = 0; i < 80; i++) begin
         if (pgood_o) break;
         cyc(1);
      end
   endtask

   task automatic bring_up(input string req);
      on_req_i = 1'b1; uv_raw_i = 1'b0; ov_raw_i = 1'b0; vbus_ok_i = 1'b1;
      wait_pg();
      chk(req, "pgood after bring-up", pgood_o, 1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "gate", gate_en_o, 0);
      chk("R1", "pgood", pgood_o, 0);
      chk("R1", "fault", fault_o, 0);
      chk("R1", "cause", cause_o, 0);
      chk("R1", "retry", retry_o, 0);
      uv_raw_i = 1'b0; vbus_ok_i = 1'b1;
      cyc(20);
      chk("R1", "gate stays off without request", gate_en_o, 0);
   endtask

   task automatic t_startup();
      do_reset();
      on_req_i = 1'b1;
      cyc(20);
      chk("R3", "gate off while UV present", gate_en_o, 0);
      uv_raw_i = 1'b0;
      cyc(DCLR);
      chk("R2", "gate off before UV release", gate_en_o, 0);
      cyc(1);
      chk("R3", "gate on after UV release", gate_en_o, 1);
      cyc(10);
      chk("R3", "no pgood without vbus_ok", pgood_o, 0);
      vbus_ok_i = 1'b1;
      cyc(PGT - 1);
      chk("R3", "pgood not yet", pgood_o, 0);
      cyc(1);
      chk("R3", "pgood after qualification", pgood_o, 1);
   endtask

   task automatic t_ilim();
      do_reset();
      bring_up("R4");
      ilim_i = 1'b1; cyc(FLT - 3); ilim_i = 1'b0;
      cyc(10);
      chk("R4", "short ilim burst keeps gate", gate_en_o, 1);
      chk("R4", "short ilim burst no retry", retry_o, 0);
      ilim_i = 1'b1;
      cyc(FLT - 1);
      chk("R4", "gate before timer expiry", gate_en_o, 1);
      cyc(1);
      ilim_i = 1'b0;
      chk("R4", "gate off at timer expiry", gate_en_o, 0);
      chk("R5", "fault pin", fault_o, 1);
      chk("R5", "cause timer", cause_o, 1);
      chk("R5", "retry count", retry_o, 1);
      cyc(OFFT);
      chk("R6", "gate off during off-time", gate_en_o, 0);
      cyc(1);
      chk("R6", "restart after off-time", gate_en_o, 1);
      chk("R6", "fault pin clears on restart", fault_o, 0);
   endtask

   task automatic t_brownout();
      do_reset();
      bring_up("R5");
      uv_raw_i = 1'b1; cyc(DSET - 1); uv_raw_i = 1'b0;
      cyc(10);
      chk("R2", "UV glitch ignored", gate_en_o, 1);
      chk("R2", "UV glitch no retry", retry_o, 0);
      uv_raw_i = 1'b1;
      cyc(DSET);
      chk("R2", "gate on until UV qualified", gate_en_o, 1);
      cyc(1);
      chk("R5", "gate off on brownout", gate_en_o, 0);
      chk("R5", "cause UV", cause_o, 2);
      chk("R5", "retry after brownout", retry_o, 1);
      uv_raw_i = 1'b0;
      wait_pg();
      ov_raw_i = 1'b1;
      cyc(DSET + 1);
      chk("R5", "gate off on OV", gate_en_o, 0);
      chk("R5", "cause OV", cause_o, 3);
      chk("R5", "retry after OV", retry_o, 2);
      ov_raw_i = 1'b0;
   endtask

   task automatic t_exhaust();
      do_reset();
      bring_up("R7");
      ilim_i = 1'b1;
      for (int k = 1; k <= MAXR; k++) begin
         wait_gate(1'b0);
         chk("R7", "retry per trip", retry_o, k);
         wait_gate(1'b1);
      end
      wait_gate(1'b0);
      chk("R7", "cause exhausted", cause_o, 5);
      chk("R7", "retry held at limit", retry_o, MAXR);
      ilim_i = 1'b0;
      cyc(60);
      chk("R9", "lock keeps gate off", gate_en_o, 0);
      chk("R9", "lock keeps fault pin", fault_o, 1);
      chk("R9", "lock keeps cause", cause_o, 5);
      unlock_i = 1'b1;
      cyc(1);
      unlock_i = 1'b0;
      chk("R9", "unlock clears cause", cause_o, 0);
      chk("R9", "unlock clears retry", retry_o, 0);
      chk("R9", "unlock clears fault pin", fault_o, 0);
      wait_pg();
      chk("R9", "restart after unlock", pgood_o, 1);
   endtask

   task automatic t_short();
      do_reset();
      bring_up("R8");
      ilim_i = 1'b1; cyc(FLT); ilim_i = 1'b0;
      wait_pg();
      chk("R8", "retry before short", retry_o, 1);
      tick_i = 1'b0; short_i = 1'b1;
      cyc(1);
      chk("R8", "gate off next clock without tick", gate_en_o, 0);
      chk("R8", "cause short", cause_o, 4);
      chk("R8", "retry unchanged", retry_o, 1);
      short_i = 1'b0; tick_i = 1'b1;
      cyc(50);
      chk("R9", "short lock holds", gate_en_o, 0);
      uv_raw_i = 1'b1;
      cyc(DSET + RMV - 1);
      chk("R9", "lock before removal window", cause_o, 4);
      cyc(1);
      chk("R9", "removal clears cause", cause_o, 0);
      chk("R9", "removal clears retry", retry_o, 0);
      chk("R9", "removal keeps gate off", gate_en_o, 0);
      uv_raw_i = 1'b0;
      wait_pg();
      chk("R9", "restart after removal", pgood_o, 1);
   endtask

   task automatic t_goodrun();
      do_reset();
      bring_up("R10");
      ilim_i = 1'b1; cyc(FLT); ilim_i = 1'b0;
      wait_pg();
      cyc(5);
      chk("R10", "retry kept early in run", retry_o, 1);
      cyc(GOOD + 5);
      chk("R10", "retry cleared after good run", retry_o, 0);
   endtask

   task automatic t_tick();
      do_reset();
      bring_up("R11");
      tick_i = 1'b0; ilim_i = 1'b1;
      cyc(30);
      chk("R11", "ilim timer frozen", gate_en_o, 1);
      uv_raw_i = 1'b1;
      cyc(30);
      chk("R11", "UV qualifier frozen", gate_en_o, 1);
      chk("R11", "retry frozen", retry_o, 0);
      ilim_i = 1'b0; tick_i = 1'b1;
      cyc(10);
      chk("R11", "timers resume with tick", cause_o, 2);
      uv_raw_i = 1'b0;
   endtask

   task automatic t_onreq();
      do_reset();
      bring_up("R12");
      on_req_i = 1'b0;
      cyc(1);
      chk("R12", "gate off on request drop", gate_en_o, 0);
      chk("R12", "pgood off on request drop", pgood_o, 0);
      chk("R12", "no fault pin", fault_o, 0);
      chk("R12", "cause none", cause_o, 0);
      cyc(20);
      chk("R12", "stays off", gate_en_o, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_startup();
      t_ilim();
      t_brownout();
      t_exhaust();
      t_short();
      t_goodrun();
      t_tick();
      t_onreq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule